// File: doc/BRIEF.md
# Packed Sub-Word Transfer Sequencer

This block sits between a 32-bit debug data register and a single-beat system bus master. One debug access to the data register becomes one or more system transfers of 8, 16 or 32 bits. The transfer size and the address-increment mode come from control fields, and the start address comes from an address input. In unpacked mode the access makes exactly one transfer. In packed mode the 32-bit register word is split into several narrow transfers at rising addresses. The byte lanes used by each transfer follow the low address bits.

Only one system transfer is outstanding at a time. The request and its attributes are held until the bus acknowledges it. Every address is aligned to the transfer size, and the burst attributes are fixed at single-beat values. The debug side sees a one-cycle ready pulse after the last transfer. That pulse also carries the assembled read word and an error flag. A bus error, or an abort request, stops the sequence once the transfer in flight has completed.

Top module: `pack_xfer_seq`

## Requirements
- R1: While reset is held and right after it, `dbg_ready` and `bus_req` are low.
- R2: A packed access (`cfg_inc` = 2'b10) makes 4 transfers for bytes, 2 for halfwords and 1 for words. Any other `cfg_inc` value makes exactly 1 transfer.
- R3: `cfg_size` maps 3'b000 to byte, 3'b001 to halfword and 3'b010 to word, and any larger code to word. `bus_size` carries the mapped code. The first transfer address is `cfg_addr` with its low log2(bytes) bits cleared.
- R4: In packed mode, each following transfer address is the previous one plus the transfer size in bytes.
- R5: `bus_wstrb` enables the lanes from `bus_addr[1:0]` upward, one lane per byte of the transfer. `bus_wdata` carries the full debug write word, unshifted.
- R6: On a read, the lanes enabled in each transfer are copied from `bus_rdata` into the assembled word. All other lanes read as zero. The word appears on `dbg_rdata` while `dbg_ready` is high.
- R7: Every transfer drives `bus_len` = 0, `bus_burst` = 2'b00 and `bus_lock` = 2'b00.
- R8: `bus_req`, `bus_addr`, `bus_wstrb` and the other attributes stay stable until a cycle with `bus_ack` high. No second transfer overlaps the first.
- R9: `dbg_ready` is high for exactly one cycle. It rises in the cycle after the acknowledge of the final transfer, and never before that acknowledge.
- R10: A transfer acknowledged with `bus_err` high ends the sequence. `dbg_err` is then high together with `dbg_ready`.
- R11: An abort seen while transfers are pending, including in the acknowledge cycle, ends the sequence after the current transfer. An abort while idle has no effect on the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_req | input | 1 | Start of a data-register access (one cycle, accepted when idle) |
| dbg_write | input | 1 | 1 = write access, 0 = read access |
| dbg_wdata | input | 32 | Data-register write word |
| cfg_size | input | 3 | Transfer size code |
| cfg_inc | input | 2 | Increment mode, 2'b10 = packed |
| cfg_addr | input | 32 | Start address of the access |
| dbg_abort | input | 1 | Abort request |
| dbg_ready | output | 1 | Access complete pulse |
| dbg_err | output | 1 | Access ended with a bus error (valid with ready) |
| dbg_rdata | output | 32 | Assembled read word (valid with ready) |
| bus_req | output | 1 | Transfer request, held until acknowledged |
| bus_write | output | 1 | Transfer direction |
| bus_addr | output | 32 | Aligned transfer address |
| bus_size | output | 3 | Transfer size code |
| bus_len | output | 4 | Burst length, always 0 |
| bus_burst | output | 2 | Burst type, always 2'b00 |
| bus_lock | output | 2 | Lock type, always 2'b00 |
| bus_wdata | output | 32 | Write data word |
| bus_wstrb | output | 4 | Byte lane enables |
| bus_ack | input | 1 | Transfer acknowledge |
| bus_err | input | 1 | Error response with the acknowledge |
| bus_rdata | input | 32 | Read data with the acknowledge |

## Verification
An abort and a transfer acknowledge can land in the same cycle, possibly together with an error response. The sequencer must then end after exactly that transfer and not one later. The bench raises the abort in the first cycle a chosen transfer is visible. The randomly drawn wait is sometimes zero, so abort and acknowledge coincide, and an error can also be drawn for that same transfer. Each case is judged by the number of transfers seen before ready, by the error flag, and by the lanes in the assembled read word.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } pxs_state_e;

    localparam logic [1:0] INC_PACKED = 2'b10;

endpackage

// File: rtl/pxs_addr_step.sv
module pxs_addr_step #(
    parameter int ADDR_W = 32,
    parameter int SZ_W   = 2
) (
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [SZ_W-1:0]   start_size_i,
    input  logic [ADDR_W-1:0] cur_addr_i,
    input  logic [SZ_W-1:0]   cur_size_i,
    output logic [ADDR_W-1:0] start_aligned_o,
    output logic [ADDR_W-1:0] cur_next_o
);

    logic [ADDR_W-1:0] start_low_mask;

    // Low-bit mask for the starting size; clearing it aligns the address.
    assign start_low_mask  = (ADDR_W'(1) << start_size_i) - ADDR_W'(1);
    assign start_aligned_o = start_addr_i & ~start_low_mask;
    // Current address is already aligned, so one step is one transfer size.
    assign cur_next_o      = cur_addr_i + (ADDR_W'(1) << cur_size_i);

endmodule

// File: rtl/pxs_lane_strobe.sv
module pxs_lane_strobe #(
    parameter int LANES  = 4,
    parameter int LANE_W = 2,
    parameter int SZ_W   = 2
) (
    input  logic [LANE_W-1:0] lane_i,
    input  logic [SZ_W-1:0]   size_i,
    output logic [LANES-1:0]  strb_o
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign strb_o[k] = (k >= int'(lane_i)) &&
                           (k <  int'(lane_i) + (1 << size_i));
    end

endmodule

// File: rtl/pxs_rd_merge.sv
module pxs_rd_merge #(
    parameter int LANES = 4
) (
    input  logic [8*LANES-1:0] acc_i,
    input  logic [8*LANES-1:0] rdata_i,
    input  logic [LANES-1:0]   strb_i,
    output logic [8*LANES-1:0] merged_o
);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign merged_o[8*k +: 8] = strb_i[k] ? rdata_i[8*k +: 8] : acc_i[8*k +: 8];
    end

endmodule

// File: rtl/pack_xfer_seq.sv
module pack_xfer_seq
    import pxs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dbg_req,
    input  logic                dbg_write,
    input  logic [8*LANES-1:0]  dbg_wdata,
    input  logic [2:0]          cfg_size,
    input  logic [1:0]          cfg_inc,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic                dbg_abort,
    output logic                dbg_ready,
    output logic                dbg_err,
    output logic [8*LANES-1:0]  dbg_rdata,
    output logic                bus_req,
    output logic                bus_write,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [2:0]          bus_size,
    output logic [3:0]          bus_len,
    output logic [1:0]          bus_burst,
    output logic [1:0]          bus_lock,
    output logic [8*LANES-1:0]  bus_wdata,
    output logic [LANES-1:0]    bus_wstrb,
    input  logic                bus_ack,
    input  logic                bus_err,
    input  logic [8*LANES-1:0]  bus_rdata
);

    localparam int DATA_W = 8 * LANES;
    localparam int MAX_SZ = $clog2(LANES);
    localparam int SZ_W   = $clog2(MAX_SZ + 1);
    localparam int LANE_W = (MAX_SZ > 0) ? MAX_SZ : 1;
    localparam int CNT_W  = $clog2(LANES + 1);

    typedef struct packed {
        pxs_state_e        state;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [SZ_W-1:0]   size;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  left;
        logic [DATA_W-1:0] acc;
        logic              err;
        logic              abort;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [SZ_W-1:0]   eff_size;
    logic [CNT_W-1:0]  start_cnt;
    logic [ADDR_W-1:0] start_aligned;
    logic [ADDR_W-1:0] next_addr;
    logic [LANES-1:0]  lane_strb;
    logic [DATA_W-1:0] merged;
    logic [CNT_W-1:0]  left_dec;
    logic              stop_now;

    // Size codes beyond the widest lane count fall back to a full word.
    assign eff_size  = (cfg_size > 3'(MAX_SZ)) ? SZ_W'(MAX_SZ) : cfg_size[SZ_W-1:0];
    assign start_cnt = (cfg_inc == INC_PACKED) ? CNT_W'(LANES >> eff_size) : CNT_W'(1);

    pxs_addr_step #(
        .ADDR_W (ADDR_W),
        .SZ_W   (SZ_W)
    ) u_addr (
        .start_addr_i    (cfg_addr),
        .start_size_i    (eff_size),
        .cur_addr_i      (seq_q.addr),
        .cur_size_i      (seq_q.size),
        .start_aligned_o (start_aligned),
        .cur_next_o      (next_addr)
    );

    pxs_lane_strobe #(
        .LANES  (LANES),
        .LANE_W (LANE_W),
        .SZ_W   (SZ_W)
    ) u_strb (
        .lane_i (seq_q.addr[LANE_W-1:0]),
        .size_i (seq_q.size),
        .strb_o (lane_strb)
    );

    pxs_rd_merge #(
        .LANES (LANES)
    ) u_merge (
        .acc_i    (seq_q.acc),
        .rdata_i  (bus_rdata),
        .strb_i   (lane_strb),
        .merged_o (merged)
    );

    assign left_dec = seq_q.left - CNT_W'(1);
    assign stop_now = (left_dec == '0) || bus_err || seq_q.abort || dbg_abort;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (dbg_req) begin
                    seq_d.state = ST_BUSY;
                    seq_d.write = dbg_write;
                    seq_d.wdata = dbg_wdata;
                    seq_d.size  = eff_size;
                    seq_d.addr  = start_aligned;
                    seq_d.left  = start_cnt;
                    seq_d.acc   = '0;
                    seq_d.err   = 1'b0;
                    seq_d.abort = 1'b0;
                end
            end
            ST_BUSY: begin
                if (dbg_abort) begin
                    seq_d.abort = 1'b1;
                end
                if (bus_ack) begin
                    if (!seq_q.write) begin
                        seq_d.acc = merged;
                    end
                    seq_d.err  = seq_q.err | bus_err;
                    seq_d.left = left_dec;
                    seq_d.addr = next_addr;
                    if (stop_now) begin
                        seq_d.state = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                seq_d.state = ST_IDLE;
            end
            default: begin
                seq_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign dbg_ready = (seq_q.state == ST_DONE);
    assign dbg_err   = seq_q.err;
    assign dbg_rdata = seq_q.acc;

    assign bus_req   = (seq_q.state == ST_BUSY);
    assign bus_write = seq_q.write;
    assign bus_addr  = seq_q.addr;
    assign bus_size  = 3'(seq_q.size);
    assign bus_len   = 4'd0;
    assign bus_burst = 2'b00;
    assign bus_lock  = 2'b00;
    assign bus_wdata = seq_q.wdata;
    assign bus_wstrb = lane_strb;

endmodule

// File: rtl/pxs_checker.sv
module pxs_checker #(
    parameter int ADDR_W = 32,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [2:0]        bus_size,
    input logic [LANES-1:0]  bus_wstrb,
    input logic              dbg_ready,
    input logic              dbg_err
);

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ((bus_addr & ((ADDR_W'(1) << bus_size) - ADDR_W'(1))) == '0)); // R3

    AST_STRB_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> ($countones(bus_wstrb) == (1 << bus_size))); // R5

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_wstrb))); // R8

    AST_NO_REQ_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ready |-> !bus_req); // R8

    AST_READY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ready |-> $past(bus_req && bus_ack)); // R9

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_ready |=> !dbg_ready); // R9

    AST_ERR_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && bus_err) |=> (dbg_ready && dbg_err)); // R10

endmodule

bind pack_xfer_seq pxs_checker #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wstrb (bus_wstrb),
    .dbg_ready (dbg_ready),
    .dbg_err   (dbg_err)
);

// File: tb/pack_xfer_seq_test.sv
module pack_xfer_seq_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_req = 1'b0;
    logic        dbg_write = 1'b0;
    logic [31:0] dbg_wdata = '0;
    logic [2:0]  cfg_size = '0;
    logic [1:0]  cfg_inc = '0;
    logic [31:0] cfg_addr = '0;
    logic        dbg_abort = 1'b0;
    logic        dbg_ready;
    logic        dbg_err;
    logic [31:0] dbg_rdata;
    logic        bus_req;
    logic        bus_write;
    logic [31:0] bus_addr;
    logic [2:0]  bus_size;
    logic [3:0]  bus_len;
    logic [1:0]  bus_burst;
    logic [1:0]  bus_lock;
    logic [31:0] bus_wdata;
    logic [3:0]  bus_wstrb;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    pack_xfer_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbg_req   (dbg_req),
        .dbg_write (dbg_write),
        .dbg_wdata (dbg_wdata),
        .cfg_size  (cfg_size),
        .cfg_inc   (cfg_inc),
        .cfg_addr  (cfg_addr),
        .dbg_abort (dbg_abort),
        .dbg_ready (dbg_ready),
        .dbg_err   (dbg_err),
        .dbg_rdata (dbg_rdata),
        .bus_req   (bus_req),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_len   (bus_len),
        .bus_burst (bus_burst),
        .bus_lock  (bus_lock),
        .bus_wdata (bus_wdata),
        .bus_wstrb (bus_wstrb),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: act cycles=%0d exp below 150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
        end
    endtask

    // Memory model: one byte per address.
    function automatic logic [7:0] memb(input logic [31:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[8*k +: 8] = memb({a[31:2], 2'(k)});
        return w;
    endfunction

    task automatic run_acc(input bit wr, input logic [2:0] sz, input logic [1:0] inc,
                           input logic [31:0] addr, input logic [31:0] wd,
                           input int err_at, input int abort_at, input bit idle_abort);
        int es, nbytes, n, stop, idx, wait_n, guard;
        bit seen, exp_err, done;
        logic [31:0] a0, ea, exp_acc;
        logic [3:0]  es_strb;
        es      = (sz > 3'd2) ? 2 : int'(sz);
        nbytes  = 1 << es;
        n       = (inc == 2'b10) ? (4 / nbytes) : 1;
        a0      = addr & ~(32'(nbytes) - 32'd1);
        stop    = n;
        if (err_at >= 0 && err_at + 1 < stop) stop = err_at + 1;
        if (abort_at >= 0 && abort_at + 1 < stop) stop = abort_at + 1;
        exp_err = (err_at >= 0) && (err_at < stop);
        exp_acc = '0;
        idx = 0; seen = 1'b0; wait_n = 0; done = 1'b0;

        if (idle_abort) begin
            @(negedge clk);
            dbg_abort = 1'b1;       // R11: abort while idle, must be ignored
        end
        @(negedge clk);
        dbg_abort = 1'b0;
        dbg_req   = 1'b1;
        dbg_write = wr;
        dbg_wdata = wd;
        cfg_size  = sz;
        cfg_inc   = inc;
        cfg_addr  = addr;
        for (guard = 0; guard < 200 && !done; guard++) begin
            @(negedge clk);
            dbg_req = 1'b0; bus_ack = 1'b0; bus_err = 1'b0; dbg_abort = 1'b0;
            if (dbg_ready) begin
                done = 1'b1;
            end else if (bus_req) begin
                ea = a0 + 32'(idx * nbytes);
                es_strb = 4'(((1 << nbytes) - 1) << ea[1:0]);
                chk(idx < stop, "R2 extra transfer", 32'(idx), 32'(stop));
                chk(bus_addr == ea, "R3/R4/R8 address", bus_addr, ea);
                if (!seen) begin
                    chk(bus_wstrb == es_strb, "R5 strobes", 32'(bus_wstrb), 32'(es_strb));
                    chk(bus_size == 3'(es), "R3 size code", 32'(bus_size), 32'(es));
                    chk(bus_write == wr, "R5 direction", 32'(bus_write), 32'(wr));
                    chk({bus_len, bus_burst, bus_lock} == 8'h00, "R7 attributes",
                        32'({bus_len, bus_burst, bus_lock}), 32'h0);
                    if (wr) chk(bus_wdata == wd, "R5 write data", bus_wdata, wd);
                    seen   = 1'b1;
                    wait_n = int'($urandom % 3);
                    if (idx == abort_at) dbg_abort = 1'b1;
                end
                if (wait_n == 0) begin
                    bus_ack   = 1'b1;
                    bus_err   = (idx == err_at);
                    bus_rdata = mem_word(ea);
                    for (int k = 0; k < 4; k++)
                        if (es_strb[k]) exp_acc[8*k +: 8] = memb({ea[31:2], 2'(k)});
                    idx  = idx + 1;
                    seen = 1'b0;
                end else begin
                    wait_n = wait_n - 1;
                end
            end
        end
        chk(done, "R9 ready seen", 32'(done), 32'd1);
        chk(idx == stop, "R2/R10/R11 transfer count", 32'(idx), 32'(stop));
        chk(dbg_err == exp_err, "R10 error flag", 32'(dbg_err), 32'(exp_err));
        if (!wr) chk(dbg_rdata == exp_acc, "R6 read word", dbg_rdata, exp_acc);
        @(negedge clk);
        chk(!dbg_ready, "R9 ready one cycle", 32'(dbg_ready), 32'd0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) begin
            @(negedge clk);
            chk(!dbg_ready && !bus_req, "R1 reset outputs", {30'd0, dbg_ready, bus_req}, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dbg_ready && !bus_req, "R1 after reset", {30'd0, dbg_ready, bus_req}, 32'd0);

        // Directed corners.
        run_acc(1'b1, 3'b000, 2'b10, 32'h2, 32'hA1B2C3D4, -1, -1, 1'b0); // R4 R5 packed bytes from 0x2
        run_acc(1'b0, 3'b001, 2'b10, 32'h2, 32'h0, -1, -1, 1'b0);        // R6 packed halves from 0x2
        run_acc(1'b0, 3'b000, 2'b01, 32'h1, 32'h0, -1, -1, 1'b0);        // R6 single byte at 0x1
        run_acc(1'b0, 3'b001, 2'b01, 32'h1, 32'h0, -1, -1, 1'b0);        // R3 half at 0x1 -> 0x0
        run_acc(1'b1, 3'b010, 2'b10, 32'h3, 32'h12345678, -1, -1, 1'b0); // R3 word at 0x3 -> 0x0
        run_acc(1'b0, 3'b111, 2'b10, 32'h7, 32'h0, -1, -1, 1'b0);        // R3 large code as word
        run_acc(1'b0, 3'b000, 2'b00, 32'h5, 32'h0, -1, -1, 1'b0);        // R2 inc 00 single
        run_acc(1'b0, 3'b000, 2'b10, 32'h10, 32'h0, 1, -1, 1'b0);        // R10 error on 2nd
        run_acc(1'b0, 3'b001, 2'b10, 32'h20, 32'h0, -1, 0, 1'b0);        // R11 abort on 1st
        run_acc(1'b0, 3'b000, 2'b10, 32'h30, 32'h0, 2, 2, 1'b0);         // R10 R11 together
        run_acc(1'b0, 3'b000, 2'b10, 32'h40, 32'h0, -1, -1, 1'b1);       // R11 idle abort ignored

        // Random mix.
        for (int i = 0; i < 400; i++) begin
            int ea_i, ab_i;
            ea_i = (($urandom % 5) == 0) ? int'($urandom % 4) : -1;
            ab_i = (($urandom % 5) == 0) ? int'($urandom % 4) : -1;
            run_acc(1'($urandom), 3'($urandom % 4), 2'($urandom), $urandom,
                    $urandom, ea_i, ab_i, (($urandom % 8) == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule